// File: doc/BRIEF.md
# Pending Floating-Point Exception Gate

This block sits in the issue path of a floating-point unit. It sees each decoded instruction once, as an escape byte (0xD8 to 0xDF) with its mod/rm byte, or as a lone wait opcode. For each one it decides whether an unmasked exception that is still pending must be delivered first. The decision uses the exception summary bit of the status word. While that bit is set, an ordinary escape instruction or a wait is turned into a trap. A small set of no-wait control instructions still proceeds, because it must be able to inspect or clear the pending state.

A trap carries a fixed vector number and a zero error code. It also hands back the instruction pointer that was captured when the instruction entered the gate, so the faulting instruction can be restarted. A wait that meets no pending exception is marked as a no-operation. Executing the instruction is left to the units downstream.

Instructions arrive on a valid/ready stream and decisions leave on another. A transfer happens on a rising edge where valid and ready are both high. The decision appears one cycle after the instruction is accepted and is held until the consumer takes it. The input is ready whenever the output slot is empty or is being drained in the same cycle.

Top module: `pexg_gate`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: `in_ready` equals `!out_valid || out_ready`. An instruction accepted on one edge produces its decision with `out_valid` high from the next edge on.
- R3: While `out_valid` is high and `out_ready` is low, every output field holds its value and `out_valid` stays high.
- R4: While `exc_summary` is low at acceptance, every instruction proceeds.
- R5: An escape byte has its top five bits equal to 11011. Its combined code is `{modrm, opcode}` (mod/rm in bits 15:8). An escape whose code ANDed with 0xF803 equals 0xE003 proceeds even when `exc_summary` is high.
- R6: An escape whose code ANDed with 0x3003 equals 0x3001, and whose code ANDed with 0xC000 is not 0xC000, proceeds even when `exc_summary` is high.
- R7: Any other escape accepted while `exc_summary` is high traps.
- R8: The wait opcode 0x9B traps when `exc_summary` is high. Otherwise it proceeds with `out_nop` high.
- R9: A trap reports `out_vector` = 16 and `out_error` = 0. A proceed reports `out_vector` = 0 and `out_error` = 0.
- R10: `out_resume_ip` equals the `in_entry_ip` captured when the instruction was accepted.
- R11: While `out_valid` is high, exactly one of `out_trap` and `out_proceed` is high. While it is low, `out_trap`, `out_proceed` and `out_nop` are all low.
- R12: A byte that is neither an escape nor the wait opcode proceeds with `out_nop` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present on the input stream |
| in_ready | output | 1 | Gate can accept an instruction |
| in_opcode | input | 8 | Escape byte or wait opcode |
| in_modrm | input | 8 | Mod/rm byte; ignored for the wait opcode |
| in_entry_ip | input | IP_W (32) | Instruction pointer at instruction entry |
| exc_summary | input | 1 | Exception summary bit of the status word |
| out_valid | output | 1 | Decision present on the output stream |
| out_ready | input | 1 | Consumer takes the decision |
| out_trap | output | 1 | Pending exception must be delivered |
| out_proceed | output | 1 | Instruction may execute |
| out_nop | output | 1 | Proceeding wait; nothing to execute |
| out_vector | output | VEC_W (8) | Trap vector, 16 on a trap, else 0 |
| out_error | output | ERR_W (16) | Trap error code, always 0 |
| out_resume_ip | output | IP_W (32) | Saved entry pointer for restart |

## Verification
The assertions assume the producer keeps `in_opcode`, `in_modrm`, `in_entry_ip` and `exc_summary` steady whenever `in_valid` is high. They also assume `out_ready` is a plain level with no tie to `out_valid`. The stimulus changes inputs only at the falling edge and drops `in_valid` after each transfer. It sweeps all 256 mod/rm values under every escape byte with the summary bit both clear and set, and adds the wait opcode and a few unrelated bytes. One sequence holds the consumer off while a second instruction waits, to exercise the stall path.

// File: rtl/pexg_pkg.sv
package pexg_pkg;
  localparam logic [4:0]  ESC_TOP     = 5'b11011;
  localparam logic [15:0] CTL_MASK_A  = 16'hF803;
  localparam logic [15:0] CTL_MATCH_A = 16'hE003;
  localparam logic [15:0] CTL_MASK_B  = 16'h3003;
  localparam logic [15:0] CTL_MATCH_B = 16'h3001;
  localparam logic [15:0] REG_FORM    = 16'hC000;

  typedef struct packed {
    logic trap;
    logic proceed;
    logic nop;
  } verdict_t;
endpackage

// File: rtl/pexg_classify.sv
module pexg_classify
  import pexg_pkg::*;
#(
  parameter logic [7:0] WAIT_OP = 8'h9B
) (
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  input  logic       summary,
  output verdict_t   verdict
);
  logic [15:0] code;
  logic        is_esc;
  logic        is_wait;
  logic        exempt_a;
  logic        exempt_b;
  logic        must_trap;

  always_comb begin
    code      = {modrm, opcode};
    is_esc    = (opcode[7:3] == ESC_TOP);
    is_wait   = (opcode == WAIT_OP);
    exempt_a  = ((code & CTL_MASK_A) == CTL_MATCH_A);
    exempt_b  = ((code & CTL_MASK_B) == CTL_MATCH_B) && ((code & REG_FORM) != REG_FORM);
    must_trap = summary && (is_wait || (is_esc && !(exempt_a || exempt_b)));
    verdict.trap    = must_trap;
    verdict.proceed = !must_trap;
    verdict.nop     = is_wait && !summary;
  end

  always_comb begin
    assert (!(verdict.nop && verdict.trap)) else $error("AST_NOP_NOT_TRAP"); // R8
  end
endmodule

// File: rtl/pexg_stage.sv
module pexg_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         held;
  logic [W-1:0] store;

  assign up_ready = !held || dn_ready;
  assign dn_valid = held;
  assign dn_data  = store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      store <= '0;
    end else if (up_ready) begin
      held <= up_valid;
      if (up_valid) store <= up_data;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    held && !dn_ready |=> held && $stable(store)) else $error("AST_STALL_HOLDS"); // R3
endmodule

// File: rtl/pexg_gate.sv
module pexg_gate
  import pexg_pkg::*;
#(
  parameter int unsigned        IP_W     = 32,
  parameter int unsigned        VEC_W    = 8,
  parameter int unsigned        ERR_W    = 16,
  parameter logic [VEC_W-1:0]   TRAP_VEC = 16,
  parameter logic [7:0]         WAIT_OP  = 8'h9B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [7:0]       in_modrm,
  input  logic [IP_W-1:0]  in_entry_ip,
  input  logic             exc_summary,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_trap,
  output logic             out_proceed,
  output logic             out_nop,
  output logic [VEC_W-1:0] out_vector,
  output logic [ERR_W-1:0] out_error,
  output logic [IP_W-1:0]  out_resume_ip
);
  localparam int unsigned VW = $bits(verdict_t);
  localparam int unsigned SW = VW + IP_W;

  verdict_t        verdict_in;
  verdict_t        verdict_q;
  logic [SW-1:0]   slot_in;
  logic [SW-1:0]   slot_q;

  pexg_classify #(.WAIT_OP(WAIT_OP)) u_classify (
    .opcode  (in_opcode),
    .modrm   (in_modrm),
    .summary (exc_summary),
    .verdict (verdict_in)
  );

  assign slot_in = {verdict_in, in_entry_ip};

  pexg_stage #(.W(SW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (slot_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (slot_q)
  );

  assign verdict_q     = verdict_t'(slot_q[SW-1:IP_W]);
  assign out_resume_ip = slot_q[IP_W-1:0];
  assign out_trap      = out_valid && verdict_q.trap;
  assign out_proceed   = out_valid && verdict_q.proceed;
  assign out_nop       = out_valid && verdict_q.nop;
  assign out_vector    = out_trap ? TRAP_VEC : '0;
  assign out_error     = '0;

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_trap, out_proceed}) == 1) else $error("AST_ONE_VERDICT"); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_trap || out_proceed || out_nop)) else $error("AST_IDLE_QUIET"); // R11
  AST_CLEAR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !exc_summary |=> out_valid && out_proceed) else $error("AST_CLEAR_PASSES"); // R4
  AST_WAIT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && exc_summary && in_opcode == WAIT_OP |=> out_trap) else $error("AST_WAIT_TRAPS"); // R8
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> out_vector == TRAP_VEC && out_error == '0) else $error("AST_TRAP_VECTOR"); // R9
  AST_IP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_resume_ip == $past(in_entry_ip)) else $error("AST_IP_CAPTURE"); // R10
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready) else $error("AST_READY_RULE"); // R2
endmodule

// File: tb/test_pexg_gate.sv
module test_pexg_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [7:0]  in_modrm = '0;
  logic [31:0] in_entry_ip = '0;
  logic        exc_summary = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_trap, out_proceed, out_nop;
  logic [7:0]  out_vector;
  logic [15:0] out_error;
  logic [31:0] out_resume_ip;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pexg_gate i_pexg_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_modrm(in_modrm), .in_entry_ip(in_entry_ip),
    .exc_summary(exc_summary), .out_valid(out_valid), .out_ready(out_ready),
    .out_trap(out_trap), .out_proceed(out_proceed), .out_nop(out_nop),
    .out_vector(out_vector), .out_error(out_error), .out_resume_ip(out_resume_ip)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_trap(input logic [7:0] op, input logic [7:0] mr, input logic s);
    logic [15:0] code;
    logic ex;
    code = {mr, op};
    ex = ((code & 16'hF803) == 16'hE003) ||
         (((code & 16'h3003) == 16'h3001) && ((code & 16'hC000) != 16'hC000));
    return s && (op == 8'h9B || (op >= 8'hD8 && !ex));
  endfunction

  function automatic string req_of(input logic [7:0] op, input logic [7:0] mr, input logic s);
    logic [15:0] code;
    code = {mr, op};
    if (!s) return "R4";
    if (op == 8'h9B) return "R8";
    if (op < 8'hD8) return "R12";
    if ((code & 16'hF803) == 16'hE003) return "R5";
    if (((code & 16'h3003) == 16'h3001) && ((code & 16'hC000) != 16'hC000)) return "R6";
    return "R7";
  endfunction

  task automatic run_one(input logic [7:0] op, input logic [7:0] mr, input logic s);
    logic t;
    logic [31:0] ip;
    ip = {op, mr, op ^ mr, 7'h2D, s};
    @(negedge clk);
    in_opcode = op; in_modrm = mr; exc_summary = s; in_entry_ip = ip;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    t = exp_trap(op, mr, s);
    chk(req_of(op, mr, s), {61'd0, out_valid, out_trap, out_proceed},
        {61'd0, 1'b1, t, !t});
    chk("R8_nop", {63'd0, out_nop}, {63'd0, (op == 8'h9B) && !s});
    chk("R9", {40'd0, out_vector, out_error}, {40'd0, t ? 8'd16 : 8'd0, 16'd0});
    chk("R10", {32'd0, out_resume_ip}, {32'd0, ip});
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {62'd0, out_valid, in_ready}, {62'd0, 1'b0, 1'b1});

    for (int s = 0; s < 2; s++)
      for (int op = 8'hD8; op <= 8'hDF; op++)
        for (int mr = 0; mr < 256; mr++)
          run_one(8'(op), 8'(mr), 1'(s));

    run_one(8'h9B, 8'h00, 1'b1);
    run_one(8'h9B, 8'hFF, 1'b0);
    run_one(8'h90, 8'h11, 1'b1);
    run_one(8'hD7, 8'hE0, 1'b1);
    run_one(8'hE0, 8'h38, 1'b0);

    // back-pressure: A held while B waits
    @(negedge clk);
    in_opcode = 8'hD8; in_modrm = 8'hC1; exc_summary = 1'b1; in_entry_ip = 32'hAAAA_0001;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_opcode = 8'hDB; in_modrm = 8'hE3; in_entry_ip = 32'hBBBB_0002;
    chk("R2", {63'd0, in_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R3", {29'd0, out_valid, out_trap, out_proceed, out_resume_ip},
        {29'd0, 1'b1, 1'b1, 1'b0, 32'hAAAA_0001});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", {29'd0, out_valid, out_trap, out_proceed, out_resume_ip},
        {29'd0, 1'b1, 1'b0, 1'b1, 32'hBBBB_0002});
    @(posedge clk);
    @(negedge clk);
    chk("R11", {60'd0, out_valid, out_trap, out_proceed, out_nop}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule